// File: doc/BRIEF.md
# Four-phase handshake stage controller

This block is the control part of one stage in a self-timed FIFO, expressed as a clocked, synthesizable model. It talks to an upstream producer through a left port (request in, acknowledge out) and to a downstream consumer through a right port (request out, acknowledge in). Both ports use four-phase return-to-zero signalling: request rises, acknowledge rises, request falls, acknowledge falls. A clock samples the two request/acknowledge inputs, and every state-holding element is a register, so each output can change at most once per clock.

A parameter picks one of two variants. The simple variant holds its state in a single Muller C-element, so the left acknowledge is tied to the right request and the two sides move in lock step. The decoupled variant adds an internal "stage full" flag. With it, the left handshake can return to zero and a new item can be accepted while the right side is still finishing its own return-to-zero phase. Data latches and delay matching lie outside the block.

Top module: `hs_stage_ctrl`

## Requirements
- R1: While the synchronous active-high reset is sampled high, both outputs (left acknowledge, right request) are 0 one clock edge later, and the decoupled variant's full flag is clear.
- R2: Simple variant: when left request and the inverted right acknowledge agree at a clock edge, right request takes that common value after the edge.
- R3: Simple variant: when left request and the inverted right acknowledge differ at a clock edge, right request keeps its previous value.
- R4: Simple variant: left acknowledge equals right request at every sampled point.
- R5: Decoupled variant: at an edge where left request is 1, left acknowledge is 0 and the stage is empty, left acknowledge becomes 1 and the stage becomes full. This holds even while right acknowledge is still 1.
- R6: Decoupled variant: at an edge where left request is 0 and left acknowledge is 1, left acknowledge becomes 0.
- R7: Decoupled variant: at an edge where the stage is full, right request is 0 and right acknowledge is 0, right request becomes 1. Right request never rises in the same edge as the capture that fills the stage.
- R8: Decoupled variant: at an edge where right request and right acknowledge are both 1, right request becomes 0 and the stage becomes empty.
- R9: Decoupled variant: while the stage is full, a raised left request is not acknowledged (left acknowledge stays 0).
- R10: In both variants, left acknowledge rises only after left request was 1 and falls only after it was 0. Right request rises only after right acknowledge was 0 and falls only after it was 1.
- R11: In both variants, a producer and a consumer that obey the protocol move every item through the stage: after N left handshakes, exactly N right handshakes have completed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| lreq_i | input | 1 | Left-side request from the producer |
| lack_o | output | 1 | Left-side acknowledge to the producer |
| rreq_o | output | 1 | Right-side request to the consumer |
| rack_i | input | 1 | Right-side acknowledge from the consumer |

## Verification
The bench builds two instances side by side, one with VARIANT set to the C-element form and one with the decoupled form, both with the default reset state. The C-element instance exposes the join-and-hold truth table and the lock-step coupling of the two sides. The decoupled instance exposes the cycle ordering of capture and issue, the refusal of a second item while full, and acceptance of a new item while the consumer still holds its acknowledge high. Both run long handshake streams with fast and slow consumers under a protocol monitor.

// File: rtl/hs_stage_pkg.sv
package hs_stage_pkg;

   typedef enum logic [0:0] {
      HS_SIMPLE    = 1'b0,
      HS_DECOUPLED = 1'b1
   } hs_variant_e;

   typedef struct packed {
      logic lack;
      logic rreq;
   } hs_out_t;

endpackage

// File: rtl/hs_celem.sv
module hs_celem #(
   parameter int   NUM_IN  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NUM_IN-1:0] in_i,
   output logic              out_o
);

   if (NUM_IN < 2) begin : g_bad_width
      $error("hs_celem: NUM_IN must be at least 2");
   end

   logic state_q;
   logic all_hi;
   logic all_lo;

   assign all_hi = &in_i;
   assign all_lo = ~|in_i;

   always_ff @(posedge clk) begin
      if (rst)         state_q <= RST_VAL;
      else if (all_hi) state_q <= 1'b1;
      else if (all_lo) state_q <= 1'b0;
   end

   assign out_o = state_q;

endmodule

// File: rtl/hs_core_simple.sv
module hs_core_simple (
   input  logic clk,
   input  logic rst,
   input  logic lreq_i,
   input  logic rack_i,
   output logic lack_o,
   output logic rreq_o
);

   logic [1:0] join_in;
   logic       join_out;

   assign join_in = {lreq_i, ~rack_i};

   hs_celem #(
      .NUM_IN (2),
      .RST_VAL(1'b0)
   ) u_join (
      .clk  (clk),
      .rst  (rst),
      .in_i (join_in),
      .out_o(join_out)
   );

   assign rreq_o = join_out;
   assign lack_o = join_out;

endmodule

// File: rtl/hs_core_decoupled.sv
module hs_core_decoupled (
   input  logic clk,
   input  logic rst,
   input  logic lreq_i,
   input  logic rack_i,
   output logic lack_o,
   output logic rreq_o
);

   logic full_q;
   logic lack_q;
   logic rreq_q;
   logic capture;
   logic left_rtz;
   logic issue;
   logic release_item;

   assign capture      = lreq_i & ~lack_q & ~full_q;
   assign left_rtz     = ~lreq_i & lack_q;
   assign issue        = full_q & ~rreq_q & ~rack_i;
   assign release_item = rreq_q & rack_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         lack_q <= 1'b0;
      end else if (capture) begin
         lack_q <= 1'b1;
      end else if (left_rtz) begin
         lack_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         full_q <= 1'b0;
      end else if (capture) begin
         full_q <= 1'b1;
      end else if (release_item) begin
         full_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rreq_q <= 1'b0;
      end else if (issue) begin
         rreq_q <= 1'b1;
      end else if (release_item) begin
         rreq_q <= 1'b0;
      end
   end

   assign lack_o = lack_q;
   assign rreq_o = rreq_q;

endmodule

// File: rtl/hs_stage_ctrl.sv
module hs_stage_ctrl #(
   parameter hs_stage_pkg::hs_variant_e VARIANT = hs_stage_pkg::HS_SIMPLE
) (
   input  logic clk,
   input  logic rst,
   input  logic lreq_i,
   output logic lack_o,
   output logic rreq_o,
   input  logic rack_i
);

   import hs_stage_pkg::*;

   hs_out_t outs;

   if (VARIANT == HS_SIMPLE) begin : g_simple
      hs_core_simple u_core (
         .clk   (clk),
         .rst   (rst),
         .lreq_i(lreq_i),
         .rack_i(rack_i),
         .lack_o(outs.lack),
         .rreq_o(outs.rreq)
      );
   end else if (VARIANT == HS_DECOUPLED) begin : g_decoupled
      hs_core_decoupled u_core (
         .clk   (clk),
         .rst   (rst),
         .lreq_i(lreq_i),
         .rack_i(rack_i),
         .lack_o(outs.lack),
         .rreq_o(outs.rreq)
      );
   end else begin : g_bad_variant
      $error("hs_stage_ctrl: unknown VARIANT");
      assign outs = '0;
   end

   assign lack_o = outs.lack;
   assign rreq_o = outs.rreq;

endmodule

// File: rtl/hs_stage_chk.sv
module hs_stage_chk #(
   parameter hs_stage_pkg::hs_variant_e VARIANT = hs_stage_pkg::HS_SIMPLE
) (
   input logic clk,
   input logic rst,
   input logic lreq_i,
   input logic lack_o,
   input logic rreq_o,
   input logic rack_i
);

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!lack_o && !rreq_o));

   // R10
   lack_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(lack_o) |-> $past(lreq_i));

   // R10
   lack_fall_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(lack_o) |-> !$past(lreq_i));

   // R10
   rreq_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(rreq_o) |-> !$past(rack_i));

   // R10
   rreq_fall_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rreq_o) |-> $past(rack_i));

   if (VARIANT == hs_stage_pkg::HS_DECOUPLED) begin : g_dec_chk
      // R9
      no_capture_pending_chk: assert property (@(posedge clk) disable iff (rst)
         $rose(lack_o) |-> !$past(rreq_o));

      // R7
      no_same_edge_issue_chk: assert property (@(posedge clk) disable iff (rst)
         $rose(lack_o) |-> !$rose(rreq_o));
   end else begin : g_simple_chk
      // R2
      join_high_chk: assert property (@(posedge clk) disable iff (rst)
         (lreq_i && !rack_i) |=> rreq_o);

      // R3
      mixed_hold_chk: assert property (@(posedge clk) disable iff (rst)
         (lreq_i == rack_i) |=> $stable(rreq_o));
   end

endmodule

bind hs_stage_ctrl hs_stage_chk #(.VARIANT(VARIANT)) u_hs_chk (
   .clk   (clk),
   .rst   (rst),
   .lreq_i(lreq_i),
   .lack_o(lack_o),
   .rreq_o(rreq_o),
   .rack_i(rack_i)
);

// File: tb/tb_hs_stage_ctrl.sv
module tb_hs_stage_ctrl;

   import hs_stage_pkg::*;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] lreq = 2'b00;
   logic [1:0] rack = 2'b00;
   logic [1:0] lack;
   logic [1:0] rreq;

   int total = 0;
   int bad   = 0;
   int viol [2];

   always #5 clk = ~clk;

   hs_stage_ctrl #(.VARIANT(HS_SIMPLE)) dut (
      .clk(clk), .rst(rst), .lreq_i(lreq[0]), .lack_o(lack[0]),
      .rreq_o(rreq[0]), .rack_i(rack[0]));

   hs_stage_ctrl #(.VARIANT(HS_DECOUPLED)) dut_dec (
      .clk(clk), .rst(rst), .lreq_i(lreq[1]), .lack_o(lack[1]),
      .rreq_o(rreq[1]), .rack_i(rack[1]));

   task automatic check(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   // protocol monitor (R10)
   always @(posedge clk) begin
      logic [1:0] li, ri, la, rr;
      logic       was_rst;
      li = lreq; ri = rack; la = lack; rr = rreq; was_rst = rst;
      #1;
      if (!was_rst) begin
         for (int i = 0; i < 2; i++) begin
            if (!la[i] && lack[i] && !li[i]) viol[i]++;
            if (la[i] && !lack[i] && li[i])  viol[i]++;
            if (!rr[i] && rreq[i] && ri[i])  viol[i]++;
            if (rr[i] && !rreq[i] && !ri[i]) viol[i]++;
         end
      end
   end

   task automatic do_reset();
      rst = 1'b1; lreq = 2'b00; rack = 2'b00;
      step(); step();
      rst = 1'b0;
   endtask

   task automatic t_reset();
      lreq = 2'b11;
      step();
      rst = 1'b1;
      step();
      for (int i = 0; i < 2; i++) begin
         check("R1 lack after reset", lack[i], 1'b0);
         check("R1 rreq after reset", rreq[i], 1'b0);
      end
      do_reset();
   endtask

   task automatic t_simple_table();
      lreq[0] = 1'b0; rack[0] = 1'b0; step();
      check("R3 hold low on mixed 0/1", rreq[0], 1'b0);
      lreq[0] = 1'b1; step();
      check("R2 join to 1", rreq[0], 1'b1);
      check("R4 lack follows rreq", lack[0], 1'b1);
      lreq[0] = 1'b0; step();
      check("R3 hold high on mixed", rreq[0], 1'b1);
      lreq[0] = 1'b1; rack[0] = 1'b1; step();
      check("R3 hold high on mixed 1/0", rreq[0], 1'b1);
      lreq[0] = 1'b0; step();
      check("R2 join to 0", rreq[0], 1'b0);
      check("R4 lack follows rreq low", lack[0], 1'b0);
      lreq[0] = 1'b1; step();
      check("R3 hold low with rack high", rreq[0], 1'b0);
      rack[0] = 1'b0; lreq[0] = 1'b0; step();
      do_reset();
   endtask

   task automatic t_dec_sequence();
      lreq[1] = 1'b1; step();
      check("R5 capture acks left", lack[1], 1'b1);
      check("R7 no issue on capture edge", rreq[1], 1'b0);
      step();
      check("R7 issue one edge later", rreq[1], 1'b1);
      check("R6 lack holds while lreq high", lack[1], 1'b1);
      lreq[1] = 1'b0; step();
      check("R6 lack returns to zero", lack[1], 1'b0);
      check("R8 rreq holds without rack", rreq[1], 1'b1);
      lreq[1] = 1'b1; step(); step();
      check("R9 no ack while full", lack[1], 1'b0);
      rack[1] = 1'b1; step();
      check("R8 release drops rreq", rreq[1], 1'b0);
      check("R9 still no ack on release edge", lack[1], 1'b0);
      step();
      check("R5 capture while rack high", lack[1], 1'b1);
      check("R7 no issue while rack high", rreq[1], 1'b0);
      step();
      check("R7 still waits for rack low", rreq[1], 1'b0);
      rack[1] = 1'b0; step();
      check("R7 issue after rack low", rreq[1], 1'b1);
      do_reset();
   endtask

   task automatic t_stream(input int idx, input int n, input int slow);
      int got = 0;
      fork
         begin
            for (int k = 0; k < n; k++) begin
               lreq[idx] = 1'b1;
               do step(); while (lack[idx] !== 1'b1);
               lreq[idx] = 1'b0;
               do step(); while (lack[idx] !== 1'b0);
            end
         end
         begin
            for (int k = 0; k < n; k++) begin
               while (rreq[idx] !== 1'b1) step();
               repeat (slow) step();
               rack[idx] = 1'b1;
               do step(); while (rreq[idx] !== 1'b0);
               repeat (slow) step();
               rack[idx] = 1'b0;
               got++;
            end
         end
      join
      total++;
      if (got != n) begin
         bad++;
         $display("FAIL R11 items out: actual=%0d expected=%0d", got, n);
      end
      step(); step();
      check("R11 idle lack after stream", lack[idx], 1'b0);
      check("R11 idle rreq after stream", rreq[idx], 1'b0);
      do_reset();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      viol[0] = 0; viol[1] = 0;
      do_reset();
      t_reset();
      t_simple_table();
      t_dec_sequence();
      t_stream(0, 8, 0);
      t_stream(0, 6, 3);
      t_stream(1, 8, 0);
      t_stream(1, 6, 4);
      for (int i = 0; i < 2; i++) begin
         total++;
         if (viol[i] != 0) begin
            bad++;
            $display("FAIL R10 protocol edges dut%0d: actual=%0d expected=0", i, viol[i]);
         end
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule